// File: doc/BRIEF.md
# Serial line modem status controller

This block keeps the dataset (modem-control) status of a single serial line. The host writes three control bits: data-terminal-ready (DTR), request-to-send (RTS) and the dataset-interrupt enable. The block holds four read-only indications: ring, clear-to-send (CTS), carrier-detect (CD) and a sticky dataset-change flag. These indications are not sampled from pins. They are derived from line connect and disconnect events and from the DTR handshake.

When the host drops DTR on a live line, the block emits a one-cycle hang-up pulse toward the line and treats the line as disconnected. Each time the dataset-change flag is set while interrupts are enabled, the block emits a one-cycle "set" pulse on its dataset-interrupt pair. Reading status, disabling the enable, or resetting the line emits a one-cycle "clear" pulse. A host reading the status word consumes the dataset-change flag.

Top module: `mdm_line_status`

## Requirements
- R1: While `rst_n` is low, `status_o` is zero, `hangup_o`, `dsi_set_o` and `dsi_clr_o` are low, and the line is held as disconnected.
- R2: Status word layout: bit 15 dataset-change, bit 14 ring, bit 13 CTS, bit 12 CD, bit 5 interrupt enable, bit 2 RTS, bit 1 DTR. A connect event on a disconnected line always sets dataset-change. If DTR is 1 it also sets CD and CTS; otherwise it sets ring.
- R3: A write that takes DTR from 0 to 1 on a connected line clears ring and sets CD, CTS and dataset-change.
- R4: A write that takes DTR from 1 to 0 on a connected line pulses `hangup_o` for exactly one cycle and disconnects the line. It sets dataset-change if CD was 1. Any write that changes DTR without taking the R3 path clears CD, ring and CTS.
- R5: A disconnect event on a connected line sets dataset-change if CD was 1, and clears CD, ring and CTS.
- R6: Whenever a connect, disconnect or DTR-change event sets dataset-change, `dsi_set_o` pulses for one cycle if the enable is 1. For a write, this is the enable being written. `dsi_set_o` and `dsi_clr_o` are never high together.
- R7: A status read strobe clears dataset-change and pulses `dsi_clr_o`.
- R8: Writing the enable (data bit 5) as 0 pulses `dsi_clr_o`. Writing it as 1 while dataset-change is 1 and the old enable is 0 pulses `dsi_set_o`. RTS and DTR are loaded from data bits 2 and 1.
- R9: A line-reset strobe clears every status bit except DTR, which keeps its value, and pulses `dsi_clr_o`. The connection state is unchanged.
- R10: Strobes arriving in the same cycle are resolved by priority: line reset, then write, then read, then disconnect, then connect. Only the winner acts.
- R11: Write data bits other than 5, 2 and 1 are ignored, and all unlisted status bits read 0.
- R12: A connect event on a line that is already connected, or a disconnect event on a line that is not connected, changes nothing.
- R13: Every strobe is sampled on a rising clock edge. Its effect on `status_o` and its pulses appear together right after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_rst_i | input | 1 | Line reset strobe |
| conn_evt_i | input | 1 | Line connected event strobe |
| disc_evt_i | input | 1 | Line dropped event strobe |
| wr_en_i | input | 1 | Host write strobe for control bits |
| wr_data_i | input | DATA_W | Host write data |
| rd_stb_i | input | 1 | Host status read strobe |
| status_o | output | DATA_W | Status word |
| hangup_o | output | 1 | One-cycle hang-up request to the line |
| dsi_set_o | output | 1 | One-cycle dataset interrupt request |
| dsi_clr_o | output | 1 | One-cycle dataset interrupt withdrawal |

## Verification
Every result of a strobe is due after exactly one rising edge. The status word, the hang-up pulse and both interrupt pulses all change at the edge that samples the strobe. The bench drives strobes on the falling edge and compares all four outputs with its own model at the next falling edge. Each pulse is therefore checked in the only cycle it may be high, and the following idle cycle checks that it has dropped again. Collisions of strobes are driven on purpose, so the priority order is exercised at that same edge.

// File: rtl/mdm_pkg.sv
package mdm_pkg;

   typedef enum logic [2:0] {
      EV_NONE = 3'd0,
      EV_LRST = 3'd1,
      EV_WR   = 3'd2,
      EV_RD   = 3'd3,
      EV_DISC = 3'd4,
      EV_CONN = 3'd5
   } mdm_evt_e;

   typedef struct packed {
      logic dsc;
      logic ring;
      logic cts;
      logic cd;
      logic ie;
      logic rts;
      logic dtr;
   } mdm_state_t;

   typedef struct packed {
      logic ie;
      logic rts;
      logic dtr;
   } mdm_ctl_t;

endpackage

// File: rtl/mdm_evt_arb.sv
module mdm_evt_arb
   import mdm_pkg::*;
(
   input  logic     line_rst_i,
   input  logic     wr_en_i,
   input  logic     rd_stb_i,
   input  logic     disc_evt_i,
   input  logic     conn_evt_i,
   output mdm_evt_e evt_o
);
   // fixed priority: reset, write, read, disconnect, connect
   always_comb begin
      if (line_rst_i)      evt_o = EV_LRST;
      else if (wr_en_i)    evt_o = EV_WR;
      else if (rd_stb_i)   evt_o = EV_RD;
      else if (disc_evt_i) evt_o = EV_DISC;
      else if (conn_evt_i) evt_o = EV_CONN;
      else                 evt_o = EV_NONE;
   end
endmodule

// File: rtl/mdm_state_next.sv
module mdm_state_next
   import mdm_pkg::*;
(
   input  mdm_evt_e   evt_i,
   input  mdm_state_t cur_i,
   input  logic       conn_i,
   input  mdm_ctl_t   ctl_i,
   output mdm_state_t nxt_o,
   output logic       conn_nxt_o,
   output logic       set_o,
   output logic       clr_o,
   output logic       hang_o
);
   always_comb begin
      nxt_o      = cur_i;
      conn_nxt_o = conn_i;
      set_o      = 1'b0;
      clr_o      = 1'b0;
      hang_o     = 1'b0;
      unique case (evt_i)
         EV_LRST: begin
            nxt_o     = '0;
            nxt_o.dtr = cur_i.dtr;
            clr_o     = 1'b1;
         end
         EV_WR: begin
            if (!ctl_i.ie)                    clr_o = 1'b1;
            else if (cur_i.dsc && !cur_i.ie)  set_o = 1'b1;
            if (ctl_i.dtr != cur_i.dtr) begin
               if (ctl_i.dtr && conn_i) begin
                  nxt_o.ring = 1'b0;
                  nxt_o.cd   = 1'b1;
                  nxt_o.cts  = 1'b1;
                  nxt_o.dsc  = 1'b1;
                  if (ctl_i.ie) set_o = 1'b1;
               end else begin
                  if (conn_i) begin
                     hang_o     = 1'b1;
                     conn_nxt_o = 1'b0;
                     if (cur_i.cd) begin
                        nxt_o.dsc = 1'b1;
                        if (ctl_i.ie) set_o = 1'b1;
                     end
                  end
                  nxt_o.cd   = 1'b0;
                  nxt_o.ring = 1'b0;
                  nxt_o.cts  = 1'b0;
               end
            end
            nxt_o.ie  = ctl_i.ie;
            nxt_o.rts = ctl_i.rts;
            nxt_o.dtr = ctl_i.dtr;
         end
         EV_RD: begin
            nxt_o.dsc = 1'b0;
            clr_o     = 1'b1;
         end
         EV_DISC: begin
            if (conn_i) begin
               conn_nxt_o = 1'b0;
               if (cur_i.cd) begin
                  nxt_o.dsc = 1'b1;
                  if (cur_i.ie) set_o = 1'b1;
               end
               nxt_o.cd   = 1'b0;
               nxt_o.ring = 1'b0;
               nxt_o.cts  = 1'b0;
            end
         end
         EV_CONN: begin
            if (!conn_i) begin
               conn_nxt_o = 1'b1;
               nxt_o.dsc  = 1'b1;
               if (cur_i.dtr) begin
                  nxt_o.cd  = 1'b1;
                  nxt_o.cts = 1'b1;
               end else begin
                  nxt_o.ring = 1'b1;
               end
               if (cur_i.ie) set_o = 1'b1;
            end
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/mdm_pulse_reg.sv
module mdm_pulse_reg #(
   parameter int W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q_o[i] <= 1'b0;
         else        q_o[i] <= d_i[i];
      end
   end
endmodule

// File: rtl/mdm_status_pack.sv
module mdm_status_pack
   import mdm_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int DSC_POS  = 15,
   parameter int RING_POS = 14,
   parameter int CTS_POS  = 13,
   parameter int CD_POS   = 12,
   parameter int IE_POS   = 5,
   parameter int RTS_POS  = 2,
   parameter int DTR_POS  = 1
) (
   input  mdm_state_t        st_i,
   output logic [DATA_W-1:0] word_o
);
   for (genvar b = 0; b < DATA_W; b++) begin : g_map
      if (b == DSC_POS)       begin : g_dsc  assign word_o[b] = st_i.dsc;  end
      else if (b == RING_POS) begin : g_ring assign word_o[b] = st_i.ring; end
      else if (b == CTS_POS)  begin : g_cts  assign word_o[b] = st_i.cts;  end
      else if (b == CD_POS)   begin : g_cd   assign word_o[b] = st_i.cd;   end
      else if (b == IE_POS)   begin : g_ie   assign word_o[b] = st_i.ie;   end
      else if (b == RTS_POS)  begin : g_rts  assign word_o[b] = st_i.rts;  end
      else if (b == DTR_POS)  begin : g_dtr  assign word_o[b] = st_i.dtr;  end
      else                    begin : g_zero assign word_o[b] = 1'b0;      end
   end
endmodule

// File: rtl/mdm_line_status.sv
module mdm_line_status
   import mdm_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int DSC_POS  = 15,
   parameter int RING_POS = 14,
   parameter int CTS_POS  = 13,
   parameter int CD_POS   = 12,
   parameter int IE_POS   = 5,
   parameter int RTS_POS  = 2,
   parameter int DTR_POS  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_rst_i,
   input  logic              conn_evt_i,
   input  logic              disc_evt_i,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              rd_stb_i,
   output logic [DATA_W-1:0] status_o,
   output logic              hangup_o,
   output logic              dsi_set_o,
   output logic              dsi_clr_o
);
   localparam int NPULSE = 3;
   localparam logic [DATA_W-1:0] FIELD_MASK =
      (DATA_W'(1) << DSC_POS) | (DATA_W'(1) << RING_POS) | (DATA_W'(1) << CTS_POS) |
      (DATA_W'(1) << CD_POS)  | (DATA_W'(1) << IE_POS)   | (DATA_W'(1) << RTS_POS) |
      (DATA_W'(1) << DTR_POS);

   // elaboration-time parameter checks
   if (DSC_POS >= DATA_W || RING_POS >= DATA_W || CTS_POS >= DATA_W || CD_POS >= DATA_W ||
       IE_POS >= DATA_W || RTS_POS >= DATA_W || DTR_POS >= DATA_W) begin : g_chk_range
      $error("mdm_line_status: field position outside status word");
   end
   if ($countones(FIELD_MASK) != 7) begin : g_chk_overlap
      $error("mdm_line_status: field positions overlap");
   end

   mdm_evt_e   evt;
   mdm_state_t st_q, st_nxt;
   logic       conn_q, conn_nxt;
   logic       set_c, clr_c, hang_c;
   mdm_ctl_t   ctl;

   assign ctl.ie  = wr_data_i[IE_POS];
   assign ctl.rts = wr_data_i[RTS_POS];
   assign ctl.dtr = wr_data_i[DTR_POS];

   mdm_evt_arb i_arb (
      .line_rst_i (line_rst_i),
      .wr_en_i    (wr_en_i),
      .rd_stb_i   (rd_stb_i),
      .disc_evt_i (disc_evt_i),
      .conn_evt_i (conn_evt_i),
      .evt_o      (evt)
   );

   mdm_state_next i_next (
      .evt_i      (evt),
      .cur_i      (st_q),
      .conn_i     (conn_q),
      .ctl_i      (ctl),
      .nxt_o      (st_nxt),
      .conn_nxt_o (conn_nxt),
      .set_o      (set_c),
      .clr_o      (clr_c),
      .hang_o     (hang_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= '0;
         conn_q <= 1'b0;
      end else begin
         st_q   <= st_nxt;
         conn_q <= conn_nxt;
      end
   end

   mdm_pulse_reg #(.W(NPULSE)) i_pulse (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({hang_c, set_c, clr_c}),
      .q_o   ({hangup_o, dsi_set_o, dsi_clr_o})
   );

   mdm_status_pack #(
      .DATA_W (DATA_W), .DSC_POS (DSC_POS), .RING_POS (RING_POS), .CTS_POS (CTS_POS),
      .CD_POS (CD_POS), .IE_POS (IE_POS), .RTS_POS (RTS_POS), .DTR_POS (DTR_POS)
   ) i_pack (
      .st_i   (st_q),
      .word_o (status_o)
   );
endmodule

// File: rtl/mdm_line_status_chk.sv
module mdm_line_status_chk #(
   parameter int DATA_W   = 16,
   parameter int DSC_POS  = 15,
   parameter int RING_POS = 14,
   parameter int CTS_POS  = 13,
   parameter int CD_POS   = 12,
   parameter int DTR_POS  = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              line_rst_i,
   input logic              conn_evt_i,
   input logic              disc_evt_i,
   input logic              wr_en_i,
   input logic              rd_stb_i,
   input logic [DATA_W-1:0] status_o,
   input logic              hangup_o,
   input logic              dsi_set_o,
   input logic              dsi_clr_o,
   input logic              conn_q
);
   AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(dsi_set_o && dsi_clr_o)); // R6

   AST_HANGUP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      hangup_o |=> !hangup_o); // R4

   AST_HANGUP_DISC: assert property (@(posedge clk) disable iff (!rst_n)
      hangup_o |-> !conn_q); // R4

   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb_i && !line_rst_i && !wr_en_i) |=> (!status_o[DSC_POS] && dsi_clr_o)); // R7

   AST_LRST_KEEP_DTR: assert property (@(posedge clk) disable iff (!rst_n)
      line_rst_i |=> ((status_o[DTR_POS] == $past(status_o[DTR_POS])) &&
                      !status_o[DSC_POS] && !status_o[CD_POS] && !status_o[RING_POS] &&
                      !status_o[CTS_POS] && dsi_clr_o)); // R9

   AST_CONN_WITH_DTR: assert property (@(posedge clk) disable iff (!rst_n)
      (conn_evt_i && !line_rst_i && !wr_en_i && !rd_stb_i && !disc_evt_i &&
       !conn_q && status_o[DTR_POS])
      |=> (status_o[CD_POS] && status_o[CTS_POS] && status_o[DSC_POS])); // R2

   AST_RING_NOT_CD: assert property (@(posedge clk) disable iff (!rst_n)
      !(status_o[RING_POS] && status_o[CD_POS])); // R2

   AST_CD_WITH_CTS: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[CD_POS] == status_o[CTS_POS]); // R3
endmodule

bind mdm_line_status mdm_line_status_chk #(
   .DATA_W (DATA_W), .DSC_POS (DSC_POS), .RING_POS (RING_POS), .CTS_POS (CTS_POS),
   .CD_POS (CD_POS), .DTR_POS (DTR_POS)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .line_rst_i (line_rst_i),
   .conn_evt_i (conn_evt_i),
   .disc_evt_i (disc_evt_i),
   .wr_en_i    (wr_en_i),
   .rd_stb_i   (rd_stb_i),
   .status_o   (status_o),
   .hangup_o   (hangup_o),
   .dsi_set_o  (dsi_set_o),
   .dsi_clr_o  (dsi_clr_o),
   .conn_q     (conn_q)
);

// File: tb/test_mdm_line_status.sv
module test_mdm_line_status;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        line_rst = 1'b0, conn_evt = 1'b0, disc_evt = 1'b0, wr_en = 1'b0, rd_stb = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] status;
   logic        hangup, dsi_set, dsi_clr;

   int  checks = 0;
   int  errors = 0;
   bit  finished = 1'b0;

   // reference model state
   bit m_dsc, m_ring, m_cts, m_cd, m_ie, m_rts, m_dtr, m_conn;
   bit e_set, e_clr, e_hang;

   always #5 clk = ~clk;

   mdm_line_status i_mdm_line_status (
      .clk (clk), .rst_n (rst_n), .line_rst_i (line_rst), .conn_evt_i (conn_evt),
      .disc_evt_i (disc_evt), .wr_en_i (wr_en), .wr_data_i (wr_data), .rd_stb_i (rd_stb),
      .status_o (status), .hangup_o (hangup), .dsi_set_o (dsi_set), .dsi_clr_o (dsi_clr)
   );

   function automatic logic [15:0] exp_word();
      return {m_dsc, m_ring, m_cts, m_cd, 6'b0, m_ie, 2'b00, m_rts, m_dtr, 1'b0};
   endfunction

   task automatic model_step(bit lr, bit cn, bit dc, bit wr, logic [15:0] wd, bit rd);
      e_set = 0; e_clr = 0; e_hang = 0;
      if (lr) begin
         {m_dsc, m_ring, m_cts, m_cd, m_ie, m_rts} = '0;
         e_clr = 1;
      end else if (wr) begin
         if (!wd[5]) e_clr = 1;
         else if (m_dsc && !m_ie) e_set = 1;
         if (wd[1] != m_dtr) begin
            if (wd[1] && m_conn) begin
               m_ring = 0; m_cd = 1; m_cts = 1; m_dsc = 1;
               if (wd[5]) e_set = 1;
            end else begin
               if (m_conn) begin
                  e_hang = 1; m_conn = 0;
                  if (m_cd) begin m_dsc = 1; if (wd[5]) e_set = 1; end
               end
               m_cd = 0; m_ring = 0; m_cts = 0;
            end
         end
         m_ie = wd[5]; m_rts = wd[2]; m_dtr = wd[1];
      end else if (rd) begin
         m_dsc = 0; e_clr = 1;
      end else if (dc) begin
         if (m_conn) begin
            m_conn = 0;
            if (m_cd) begin m_dsc = 1; if (m_ie) e_set = 1; end
            m_cd = 0; m_ring = 0; m_cts = 0;
         end
      end else if (cn) begin
         if (!m_conn) begin
            m_conn = 1; m_dsc = 1;
            if (m_dtr) begin m_cd = 1; m_cts = 1; end
            else m_ring = 1;
            if (m_ie) e_set = 1;
         end
      end
   endtask

   task automatic check(string tag);
      checks++;
      if (status !== exp_word() || hangup !== e_hang || dsi_set !== e_set || dsi_clr !== e_clr) begin
         errors++;
         $display("FAIL %s status=%h exp=%h hang=%b exp=%b set=%b exp=%b clr=%b exp=%b",
                  tag, status, exp_word(), hangup, e_hang, dsi_set, e_set, dsi_clr, e_clr);
      end
   endtask

   // called at a falling edge: drive, let one rising edge pass, check at next falling edge
   task automatic cycle(bit lr, bit cn, bit dc, bit wr, logic [15:0] wd, bit rd, string tag);
      line_rst = lr; conn_evt = cn; disc_evt = dc; wr_en = wr; wr_data = wd; rd_stb = rd;
      model_step(lr, cn, dc, wr, wd, rd);
      @(posedge clk);
      @(negedge clk);
      line_rst = 0; conn_evt = 0; disc_evt = 0; wr_en = 0; rd_stb = 0;
      check(tag);
   endtask

   function automatic string tag_of(bit lr, bit cn, bit dc, bit wr, logic [15:0] wd, bit rd);
      if (lr) return "R9";
      if (wr) return (wd[1] != m_dtr) ? ((wd[1] && m_conn) ? "R3" : "R4") : "R8";
      if (rd) return "R7";
      if (dc) return m_conn ? "R5" : "R12";
      if (cn) return m_conn ? "R12" : "R2";
      return "R13";
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int unsigned seed_sink;
      seed_sink = $urandom(32'h5EED_0042);
      repeat (3) @(negedge clk);
      e_set = 0; e_clr = 0; e_hang = 0;
      check("R1 reset state");
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release");

      // connect with DTR clear: ring
      cycle(0, 1, 0, 0, 16'h0000, 0, "R2 ring on connect");
      cycle(0, 0, 0, 0, 16'h0000, 1, "R7 read clears change");
      // raise DTR with enable: carrier + set pulse
      cycle(0, 0, 0, 1, 16'h0026, 0, "R3 DTR rise connected");
      cycle(0, 0, 0, 0, 16'h0000, 0, "R6 pulse drops");
      // drop DTR: hang-up
      cycle(0, 0, 0, 1, 16'h0020, 0, "R4 DTR fall hangup");
      cycle(0, 0, 0, 0, 16'h0000, 0, "R4 hangup single cycle");
      // enable off, connect (no pulse), enable on with change pending
      cycle(0, 0, 0, 1, 16'h0002, 0, "R8 enable off clears");
      cycle(0, 1, 0, 0, 16'h0000, 0, "R2 connect with DTR");
      cycle(0, 0, 0, 1, 16'h0022, 0, "R8 late enable sets");
      cycle(0, 1, 0, 0, 16'h0000, 0, "R12 connect while connected");
      cycle(0, 0, 1, 0, 16'h0000, 0, "R5 disconnect with carrier");
      cycle(0, 0, 1, 0, 16'h0000, 0, "R12 disconnect while idle");
      // collision: write beats connect
      cycle(0, 1, 0, 1, 16'h0002, 0, "R10 write beats connect");
      cycle(0, 1, 1, 0, 16'h0000, 1, "R10 read beats disconnect");
      cycle(1, 1, 0, 1, 16'h0026, 0, "R10 reset beats write");
      cycle(0, 0, 0, 1, 16'hFFFF, 0, "R11 unused write bits");
      cycle(1, 0, 0, 0, 16'h0000, 0, "R9 line reset keeps DTR");

      for (int n = 0; n < 4000; n++) begin
         int unsigned r;
         bit lr, cn, dc, wr, rd;
         logic [15:0] wd;
         r = $urandom % 32;
         wd = 16'($urandom);
         lr = (r == 0);
         wr = (r >= 1 && r <= 7);
         rd = (r >= 8 && r <= 11);
         dc = (r >= 12 && r <= 15);
         cn = (r >= 16 && r <= 22);
         if (r == 31) begin cn = 1; dc = ($urandom % 2) == 1; rd = ($urandom % 2) == 1; end
         cycle(lr, cn, dc, wr, wd, rd, tag_of(lr, cn, dc, wr, wd, rd));
      end

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule